// File: doc/BRIEF.md
# Privilege Mode Tracker and Address Segment Classifier

This block follows the processor's privilege level (User, Kernel or Debug) and, for every address presented with a valid strobe, works out which fixed region of the 32-bit virtual space the address falls in. In the same cycle it reports three things: whether the access is legal in the current mode, whether the region is cacheable, and whether the address hits the small debug window.

The privilege level changes on these events:
- reset;
- an ordinary exception;
- a debug exception;
- a return-from-exception strobe;
- a software request to drop into User mode.

Two saved-mode registers let a return strobe go back to the level that was active before the matching exception. The access outputs are purely combinational from the address, the valid strobe and the current registered mode. A pipeline can therefore raise an address-error exception in the same cycle. The mode itself changes only when the exception input is driven.

Top module: `priv_seg_guard`

## Requirements
- R1: After reset `curMode` is Kernel. The mode encoding is 0 = User, 1 = Kernel, 2 = Debug.
- R2: An ordinary exception (`excEvt`) sets the mode to Kernel on the next clock, from any mode. The mode held before it is saved for a later return.
- R3: A debug exception (`dbgExcEvt`) sets the mode to Debug on the next clock and wins over a simultaneous ordinary exception. When it comes from User or Kernel, the prior mode is saved. When it comes while already in Debug, the saved mode is left untouched.
- R4: In User mode a valid access at 0x80000000 or above raises `addrErr` in the same cycle. A valid access at 0x00000000 to 0x7FFFFFFF does not.
- R5: In Kernel and Debug modes `addrErr` stays low for every address.
- R6: `segId` is decoded from the address as follows:
  - 0 for 0x00000000–0x7FFFFFFF;
  - 1 for 0x80000000–0x9FFFFFFF;
  - 2 for 0xA0000000–0xBFFFFFFF;
  - 3 for 0xC0000000–0xDFFFFFFF;
  - 4 for 0xE0000000–0xFFFFFFFF.
- R7: `cacheable` is 1 for segments 0, 1, 3 and 4, and 0 for segment 2.
- R8: In Debug mode an address in 0xFF200000–0xFF3FFFFF gives `segId` = 5, `dbgWinHit` = 1 and `cacheable` = 0.
- R9: Outside Debug mode the window range decodes as segment 4: cacheable, with `dbgWinHit` low.
- R10: `excRet` acts according to the current mode:
  - in Debug, it restores the mode saved at the debug exception;
  - in Kernel, it restores the mode saved at the ordinary exception;
  - in User, it has no effect.
  The saved registers reset to Kernel.
- R11: `userDropReq` moves Kernel to User on the next clock. It has no effect in User or Debug.
- R12: Raising `addrErr` does not change the mode by itself.
- R13: With `accValid` low, `segId`, `cacheable`, `dbgWinHit` and `addrErr` are all 0.
- R14: When several mode events coincide, the priority from highest to lowest is: debug exception, ordinary exception, return, drop-to-User.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous active-high reset |
| excEvt | input | 1 | Ordinary exception taken this cycle |
| dbgExcEvt | input | 1 | Debug exception taken this cycle |
| excRet | input | 1 | Return-from-exception strobe |
| userDropReq | input | 1 | Software request to enter User mode |
| accValid | input | 1 | Address strobe |
| accAddr | input | 32 | Virtual address |
| curMode | output | 2 | Current privilege level |
| segId | output | 3 | Segment identifier |
| cacheable | output | 1 | Region is cacheable |
| dbgWinHit | output | 1 | Access hits the debug window |
| addrErr | output | 1 | Access is illegal in the current mode |

## Verification
The bench drives addresses on both sides of every segment boundary and both window edges. A design that was off by one on a boundary would report the wrong segment or cacheability there, and a design that left the window open outside Debug mode would set `dbgWinHit` in Kernel. It also walks nested exception and return sequences, for example User to Debug to Kernel and back, and fires coincident events. A design with a single saved mode, or with the wrong priority, would return to the wrong level. Finally, it makes invalid and illegal accesses with no mode event, to catch a design that leaks an error when the strobe is idle or changes mode on an error.

// File: rtl/priv_seg_pkg.sv
package priv_seg_pkg;

  typedef enum logic [1:0] {
    MODE_USER   = 2'd0,
    MODE_KERNEL = 2'd1,
    MODE_DEBUG  = 2'd2
  } privMode_e;

  typedef enum logic [2:0] {
    SEG_USER      = 3'd0,
    SEG_KCACHED   = 3'd1,
    SEG_KUNCACHED = 3'd2,
    SEG_KHIGH_LO  = 3'd3,
    SEG_KHIGH_HI  = 3'd4,
    SEG_DBGWIN    = 3'd5
  } segId_e;

  // strobes from the mode control to the address datapath
  typedef struct packed {
    logic userMode;
    logic debugMode;
  } ctrlStrobe_t;

  function automatic logic segIsCacheable(input segId_e seg);
    return !(seg == SEG_KUNCACHED || seg == SEG_DBGWIN);
  endfunction

endpackage

// File: rtl/priv_seg_ctrl.sv
module priv_seg_ctrl
  import priv_seg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        excEvt,
  input  logic        dbgExcEvt,
  input  logic        excRet,
  input  logic        userDropReq,
  output privMode_e   modeQ,
  output ctrlStrobe_t strobes
);

  privMode_e excSaveQ, dbgSaveQ;
  privMode_e modeD, excSaveD, dbgSaveD;

  always_comb begin
    modeD    = modeQ;
    excSaveD = excSaveQ;
    dbgSaveD = dbgSaveQ;
    if (dbgExcEvt) begin
      modeD = MODE_DEBUG;
      if (modeQ != MODE_DEBUG) dbgSaveD = modeQ;
    end else if (excEvt) begin
      modeD    = MODE_KERNEL;
      excSaveD = modeQ;
    end else if (excRet) begin
      case (modeQ)
        MODE_DEBUG:  modeD = dbgSaveQ;
        MODE_KERNEL: modeD = excSaveQ;
        default:     modeD = modeQ;
      endcase
    end else if (userDropReq && modeQ == MODE_KERNEL) begin
      modeD = MODE_USER;
    end
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      modeQ    <= MODE_KERNEL;
      excSaveQ <= MODE_KERNEL;
      dbgSaveQ <= MODE_KERNEL;
    end else begin
      modeQ    <= modeD;
      excSaveQ <= excSaveD;
      dbgSaveQ <= dbgSaveD;
    end
  end

  assign strobes.userMode  = (modeQ == MODE_USER);
  assign strobes.debugMode = (modeQ == MODE_DEBUG);

endmodule

// File: rtl/priv_seg_decode.sv
module priv_seg_decode
  import priv_seg_pkg::*;
#(
  parameter int              ADDR_W       = 32,
  parameter logic [ADDR_W-1:0] DBG_WIN_BASE = 32'hFF20_0000,
  parameter int              DBG_WIN_BITS = 21
) (
  input  ctrlStrobe_t       strobes,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  output logic [2:0]        segId,
  output logic              cacheable,
  output logic              dbgWinHit,
  output logic              addrErr
);

  localparam int SEL_W = 3;
  localparam logic [ADDR_W-1:0] WIN_LAST =
    DBG_WIN_BASE + ((ADDR_W'(1) << DBG_WIN_BITS) - ADDR_W'(1));

  logic [SEL_W-1:0] regionSel;
  segId_e           baseSeg, finalSeg;
  logic             inWindow, userOnly;

  assign regionSel = accAddr[ADDR_W-1 -: SEL_W];
  assign userOnly  = ~accAddr[ADDR_W-1];
  assign inWindow  = (accAddr >= DBG_WIN_BASE) && (accAddr <= WIN_LAST);

  always_comb begin
    case (regionSel)
      3'd4:    baseSeg = SEG_KCACHED;
      3'd5:    baseSeg = SEG_KUNCACHED;
      3'd6:    baseSeg = SEG_KHIGH_LO;
      3'd7:    baseSeg = SEG_KHIGH_HI;
      default: baseSeg = SEG_USER;
    endcase
  end

  assign finalSeg = (strobes.debugMode && inWindow) ? SEG_DBGWIN : baseSeg;

  assign segId     = accValid ? finalSeg : 3'd0;
  assign cacheable = accValid && segIsCacheable(finalSeg);
  assign dbgWinHit = accValid && (finalSeg == SEG_DBGWIN);
  assign addrErr   = accValid && strobes.userMode && !userOnly;

endmodule

// File: rtl/priv_seg_guard.sv
module priv_seg_guard
  import priv_seg_pkg::*;
#(
  parameter int                ADDR_W       = 32,
  parameter logic [ADDR_W-1:0] DBG_WIN_BASE = 32'hFF20_0000,
  parameter int                DBG_WIN_BITS = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              excEvt,
  input  logic              dbgExcEvt,
  input  logic              excRet,
  input  logic              userDropReq,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  output logic [1:0]        curMode,
  output logic [2:0]        segId,
  output logic              cacheable,
  output logic              dbgWinHit,
  output logic              addrErr
);

  privMode_e   modeQ;
  ctrlStrobe_t strobes;

  priv_seg_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .excEvt     (excEvt),
    .dbgExcEvt  (dbgExcEvt),
    .excRet     (excRet),
    .userDropReq(userDropReq),
    .modeQ      (modeQ),
    .strobes    (strobes)
  );

  priv_seg_decode #(
    .ADDR_W      (ADDR_W),
    .DBG_WIN_BASE(DBG_WIN_BASE),
    .DBG_WIN_BITS(DBG_WIN_BITS)
  ) u_decode (
    .strobes  (strobes),
    .accValid (accValid),
    .accAddr  (accAddr),
    .segId    (segId),
    .cacheable(cacheable),
    .dbgWinHit(dbgWinHit),
    .addrErr  (addrErr)
  );

  assign curMode = modeQ;

endmodule

// File: rtl/priv_seg_guard_chk.sv
module priv_seg_guard_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              excEvt,
  input logic              dbgExcEvt,
  input logic              excRet,
  input logic              userDropReq,
  input logic              accValid,
  input logic [ADDR_W-1:0] accAddr,
  input logic [1:0]        curMode,
  input logic [2:0]        segId,
  input logic              cacheable,
  input logic              dbgWinHit,
  input logic              addrErr
);

  a_r1_reset_kernel: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> curMode == 2'd1);

  a_r2_exc_to_kernel: assert property (@(posedge clk) disable iff (rst)
    (excEvt && !dbgExcEvt) |=> curMode == 2'd1);

  a_r3_dbg_to_debug: assert property (@(posedge clk) disable iff (rst)
    dbgExcEvt |=> curMode == 2'd2);

  a_r4_user_high_err: assert property (@(posedge clk) disable iff (rst)
    (accValid && curMode == 2'd0 && accAddr >= 32'h8000_0000) |-> addrErr);

  a_r5_priv_no_err: assert property (@(posedge clk) disable iff (rst)
    (curMode != 2'd0) |-> !addrErr);

  a_r8_win_only_debug: assert property (@(posedge clk) disable iff (rst)
    dbgWinHit |-> (curMode == 2'd2 && !cacheable && segId == 3'd5));

  a_r10_user_ret_ignored: assert property (@(posedge clk) disable iff (rst)
    (curMode == 2'd0 && excRet && !excEvt && !dbgExcEvt) |=> curMode == 2'd0);

  a_r11_drop_ignored_debug: assert property (@(posedge clk) disable iff (rst)
    (curMode == 2'd2 && userDropReq && !excEvt && !dbgExcEvt && !excRet)
      |=> curMode == 2'd2);

  a_r12_err_keeps_mode: assert property (@(posedge clk) disable iff (rst)
    (addrErr && !excEvt && !dbgExcEvt && !excRet && !userDropReq)
      |=> $stable(curMode));

  a_r13_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !accValid |-> (segId == 3'd0 && !cacheable && !dbgWinHit && !addrErr));

endmodule

bind priv_seg_guard priv_seg_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .excEvt(excEvt), .dbgExcEvt(dbgExcEvt),
  .excRet(excRet), .userDropReq(userDropReq), .accValid(accValid),
  .accAddr(accAddr), .curMode(curMode), .segId(segId),
  .cacheable(cacheable), .dbgWinHit(dbgWinHit), .addrErr(addrErr)
);

// File: tb/priv_seg_guard_bench.sv
module priv_seg_guard_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        excEvt = 0, dbgExcEvt = 0, excRet = 0, userDropReq = 0;
  logic        accValid = 0;
  logic [31:0] accAddr = '0;
  logic [1:0]  curMode;
  logic [2:0]  segId;
  logic        cacheable, dbgWinHit, addrErr;

  int vectors = 0;
  int miscompares = 0;
  bit done = 0;

  // reference state: 0 User, 1 Kernel, 2 Debug
  int mMode = 1, mExcSave = 1, mDbgSave = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  priv_seg_guard u_priv_seg_guard (
    .clk(clk), .rst(rst), .excEvt(excEvt), .dbgExcEvt(dbgExcEvt),
    .excRet(excRet), .userDropReq(userDropReq), .accValid(accValid),
    .accAddr(accAddr), .curMode(curMode), .segId(segId),
    .cacheable(cacheable), .dbgWinHit(dbgWinHit), .addrErr(addrErr)
  );

  function automatic int refSeg(input logic [31:0] a, input int mode);
    if (mode == 2 && a >= 32'hFF20_0000 && a <= 32'hFF3F_FFFF) return 5;
    if (a < 32'h8000_0000) return 0;
    if (a < 32'hA000_0000) return 1;
    if (a < 32'hC000_0000) return 2;
    if (a < 32'hE000_0000) return 3;
    return 4;
  endfunction

  task automatic cmp(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d addr=%h", tag, what, act, exp, accAddr);
    end
  endtask

  task automatic step(input bit e, input bit d, input bit r, input bit u,
                      input bit v, input logic [31:0] a, input string tag);
    int s;
    excEvt = e; dbgExcEvt = d; excRet = r; userDropReq = u;
    accValid = v; accAddr = a;
    #(CLK_PERIOD/4);
    s = refSeg(a, mMode);
    cmp(tag, "mode", int'(curMode), mMode);
    cmp(tag, "segId", int'(segId), v ? s : 0);
    cmp(tag, "cacheable", int'(cacheable), (v && s != 2 && s != 5) ? 1 : 0);
    cmp(tag, "dbgWinHit", int'(dbgWinHit), (v && s == 5) ? 1 : 0);
    cmp(tag, "addrErr", int'(addrErr), (v && mMode == 0 && a >= 32'h8000_0000) ? 1 : 0);
    @(posedge clk);
    if (d) begin
      if (mMode != 2) mDbgSave = mMode;
      mMode = 2;
    end else if (e) begin
      mExcSave = mMode;
      mMode = 1;
    end else if (r) begin
      if (mMode == 2) mMode = mDbgSave;
      else if (mMode == 1) mMode = mExcSave;
    end else if (u && mMode == 1) begin
      mMode = 0;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state, R13 idle strobe
    step(0,0,0,0,0,32'hFFFF_FFFF,"R1");
    step(0,0,0,0,0,32'h8000_0000,"R13");
    // R6 R7 R5 boundaries in Kernel
    step(0,0,0,0,1,32'h0000_0000,"R6");
    step(0,0,0,0,1,32'h7FFF_FFFF,"R6");
    step(0,0,0,0,1,32'h8000_0000,"R6");
    step(0,0,0,0,1,32'h9FFF_FFFF,"R7");
    step(0,0,0,0,1,32'hA000_0000,"R7");
    step(0,0,0,0,1,32'hBFFF_FFFF,"R7");
    step(0,0,0,0,1,32'hC000_0000,"R6");
    step(0,0,0,0,1,32'hDFFF_FFFF,"R6");
    step(0,0,0,0,1,32'hE000_0000,"R5");
    step(0,0,0,0,1,32'hFF20_0000,"R9");
    step(0,0,0,0,1,32'hFF3F_FFFF,"R9");
    // R11 drop to user
    step(0,0,0,1,0,32'h0,"R11");
    step(0,0,0,0,1,32'h7FFF_FFFF,"R4");
    step(0,0,0,0,1,32'h8000_0000,"R4");
    step(0,0,0,0,1,32'hFFFF_FFFF,"R12");
    step(0,0,0,0,0,32'hFFFF_FFFF,"R13");
    step(0,0,1,0,1,32'hC000_0000,"R10");
    step(0,0,0,1,1,32'h1234_5678,"R11");
    // R2 exception from User, return
    step(1,0,0,0,1,32'hA000_0000,"R2");
    step(0,0,1,0,1,32'hA000_0000,"R10");
    step(0,0,0,0,1,32'hA000_0000,"R10");
    // R3 debug from User
    step(0,1,0,0,1,32'h0,"R3");
    step(0,0,0,0,1,32'hFF1F_FFFF,"R8");
    step(0,0,0,0,1,32'hFF20_0000,"R8");
    step(0,0,0,0,1,32'hFF3F_FFFF,"R8");
    step(0,0,0,0,1,32'hFF40_0000,"R8");
    step(0,0,0,1,1,32'h8000_0000,"R11");
    step(0,1,0,0,1,32'hFF30_0000,"R3");
    step(1,0,0,0,1,32'hFF30_0000,"R2");
    step(0,0,0,0,1,32'hFF30_0000,"R9");
    step(0,0,1,0,0,32'h0,"R10");
    step(0,0,1,0,0,32'h0,"R10");
    step(0,0,0,0,1,32'hE000_0000,"R10");
    // R14 coincident events
    step(1,1,1,1,1,32'h0,"R14");
    step(1,0,1,1,1,32'h0,"R14");
    step(0,0,1,1,1,32'h0,"R14");
    step(0,0,1,1,1,32'h0,"R14");
    step(0,0,0,1,1,32'h8000_0000,"R14");
    // random mix
    for (int i = 0; i < 400; i++) begin
      bit e, d, r, u, v;
      logic [31:0] a;
      e = ($urandom_range(0, 15) == 0);
      d = ($urandom_range(0, 19) == 0);
      r = ($urandom_range(0, 7) == 0);
      u = ($urandom_range(0, 5) == 0);
      v = ($urandom_range(0, 3) != 0);
      a = $urandom();
      if ($urandom_range(0, 3) == 0) a = 32'hFF20_0000 + ($urandom() & 32'h003F_FFFF);
      step(e, d, r, u, v, a, "R6");
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule